// File: doc/BRIEF.md
# Main Clock Integer Predivider

This block sits between the system oscillator and the main clock tree. It lowers the main clock to a frequency between the oscillator's lowest setting (4 MHz) and the 32 kHz low-frequency clock. A 4-bit ratio field selects the setting. The value 0 passes the source clock straight through. A value N from 1 to 15 divides the source by N+1. With a 4 MHz source, for example, 1 gives 2 MHz, 3 gives 1 MHz, 7 gives 500 kHz and 15 gives 250 kHz.

The divider only acts while the system oscillator drives the main clock. It can only be switched on after asynchronous frequency-change requests have been blocked for a qualifying time. A request that breaks these rules is not carried out and raises a violation flag. Ratio changes take effect only at the end of an output period, so the divided clock never emits a shortened pulse. After the divider is switched off, a settle output tells the oscillator control when its frequency may change again.

Top module: `mclk_prediv`

## Requirements
- R1: With the ratio field at 0, or with the divider otherwise bypassed, `clk_out` follows `clk_src`: it is high while the source is high and low while the source is low.
- R2: With the divider active at field value N (1..15), `clk_out` repeats with a period of exactly N+1 source cycles.
- R3: Each divided period starts with a high phase of ceil((N+1)/2) source cycles, followed by a low phase for the rest of the period. For odd ratios the high phase is one source cycle longer than the low phase.
- R4: A new field value is adopted only after the current output period has finished. The remaining cycles of the running period keep the old ratio.
- R5: The divider is switched on from bypass only if `src_is_osc` and `async_blocked` have both been high for at least 10 consecutive source cycles. If a non-zero field arrives without this, the divider stays in bypass and `cfg_violation` is high from the next cycle.
- R6: `cfg_violation` stays high, and the divider stays in bypass, until the field returns to 0. One cycle with the field at 0 clears the flag.
- R7: If `src_is_osc` falls while the divider is active, `cfg_violation` rises on the next cycle and the divider returns to bypass at the end of the current period.
- R8: `settle_ok` is low whenever the divider is active. After the divider returns to bypass, `settle_ok` rises once 16 source cycles of bypass have elapsed.
- R9: After reset the block is in bypass, `settle_ok` is high and `cfg_violation` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Source clock from the system oscillator path |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| div_sel | input | 4 | Ratio field: 0 bypass, N gives divide-by-(N+1) |
| src_is_osc | input | 1 | High when the system oscillator is the main clock source |
| async_blocked | input | 1 | High when asynchronous fast-clock requests are blocked |
| clk_out | output | 1 | Main clock, either divided or bypassed |
| settle_ok | output | 1 | Oscillator frequency may change |
| cfg_violation | output | 1 | A ratio request broke an enabling rule and was ignored |

## Verification
Inputs change one nanosecond after a rising source edge, and the register stage picks them up at the next edge. A ratio written while the block is in bypass therefore produces its first high phase in the very next sampled cycle. A ratio written while the divider is active waits for the period boundary. The violation flag follows one edge after the offending write. `settle_ok` rises 17 edges after the last-cycle write of a disable, which is 16 edges after bypass is resumed. Each check is placed at the exact sample index that this latency count gives, and never inside a window. The ratio sweep compares every sampled cycle of three periods per ratio against a pattern computed from N.

// File: rtl/mclk_prediv_pkg.sv
package mclk_prediv_pkg;
  localparam int unsigned DEF_DIV_W      = 4;
  localparam int unsigned DEF_QUAL_CYC   = 10;
  localparam int unsigned DEF_SETTLE_CYC = 16;

  typedef enum logic {
    PATH_BYPASS  = 1'b0,
    PATH_DIVIDED = 1'b1
  } clk_path_e;
endpackage

// File: rtl/prediv_qualify.sv
module prediv_qualify #(
  parameter int unsigned DIV_W    = 4,
  parameter int unsigned QUAL_CYC = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_sel,
  input  logic             src_is_osc,
  input  logic             async_blocked,
  input  logic             active_i,
  output logic [DIV_W-1:0] req_o,
  output logic             viol_o
);
  localparam int unsigned QW = $clog2(QUAL_CYC + 1);
  localparam logic [QW-1:0] QMAX = QW'(QUAL_CYC);

  logic [QW-1:0] qcnt_q, qcnt_d;
  logic          viol_q, viol_d;
  logic          enable_ok, blocked;

  always_comb begin
    if (src_is_osc && async_blocked)
      qcnt_d = (qcnt_q == QMAX) ? qcnt_q : qcnt_q + 1'b1;
    else
      qcnt_d = '0;
    enable_ok = src_is_osc && async_blocked && (qcnt_q == QMAX);
    blocked   = viol_q || !src_is_osc || (!active_i && !enable_ok);
    req_o     = blocked ? '0 : div_sel;
    viol_d    = (div_sel != '0) && blocked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qcnt_q <= '0;
      viol_q <= 1'b0;
    end else begin
      qcnt_q <= qcnt_d;
      viol_q <= viol_d;
    end
  end

  assign viol_o = viol_q;

  // R6
  viol_needs_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_q |-> ($past(div_sel) != '0));
  // R5
  no_enable_unqualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_i && qcnt_q != QMAX) |-> (req_o == '0));
endmodule

// File: rtl/prediv_core.sv
module prediv_core #(
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] req_i,
  output logic             active_o,
  output logic             phase_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] ratio_q, ratio_d;
  logic             ph_q, ph_d;
  logic             wrap;

  function automatic logic [DIV_W-1:0] high_len(input logic [DIV_W-1:0] r);
    logic [DIV_W:0] ext;
    ext = {1'b0, r} + (DIV_W+1)'(2);
    return ext[DIV_W:1];
  endfunction

  always_comb begin
    wrap    = (cnt_q == ratio_q);
    ratio_d = wrap ? req_i : ratio_q;
    cnt_d   = wrap ? '0 : cnt_q + 1'b1;
    ph_d    = (cnt_d < high_len(ratio_d));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ratio_q <= '0;
      ph_q    <= 1'b1;
    end else begin
      cnt_q   <= cnt_d;
      ratio_q <= ratio_d;
      ph_q    <= ph_d;
    end
  end

  assign active_o = (ratio_q != '0);
  assign phase_o  = ph_q;

  // R4
  ratio_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_q != $past(ratio_q)) |-> ($past(cnt_q) == $past(ratio_q)));
  // R2
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= ratio_q);
  // R3
  period_starts_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_q != '0 && cnt_q == '0) |-> ph_q);
  // R3
  period_ends_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_q != '0 && cnt_q == ratio_q) |-> !ph_q);
endmodule

// File: rtl/prediv_settle.sv
module prediv_settle #(
  parameter int unsigned SETTLE_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  output logic settle_o
);
  localparam int unsigned SW = $clog2(SETTLE_CYC + 1);
  localparam logic [SW-1:0] SMAX = SW'(SETTLE_CYC);

  logic [SW-1:0] scnt_q, scnt_d;

  always_comb begin
    if (active_i)
      scnt_d = '0;
    else
      scnt_d = (scnt_q == SMAX) ? scnt_q : scnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scnt_q <= SMAX;
    else        scnt_q <= scnt_d;
  end

  assign settle_o = (scnt_q == SMAX) && !active_i;

  // R8
  settle_after_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(settle_o) |-> $past(!active_i));
endmodule

// File: rtl/mclk_prediv.sv
module mclk_prediv
  import mclk_prediv_pkg::*;
#(
  parameter int unsigned DIV_W      = DEF_DIV_W,
  parameter int unsigned QUAL_CYC   = DEF_QUAL_CYC,
  parameter int unsigned SETTLE_CYC = DEF_SETTLE_CYC
) (
  input  logic             clk_src,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_sel,
  input  logic             src_is_osc,
  input  logic             async_blocked,
  output logic             clk_out,
  output logic             settle_ok,
  output logic             cfg_violation
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [DIV_W-1:0] req;
  logic             active, phase;
  clk_path_e        path;

  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  prediv_qualify #(.DIV_W(DIV_W), .QUAL_CYC(QUAL_CYC)) qual_i (
    .clk           (clk_src),
    .rst_n         (rst_int_n),
    .div_sel       (div_sel),
    .src_is_osc    (src_is_osc),
    .async_blocked (async_blocked),
    .active_i      (active),
    .req_o         (req),
    .viol_o        (cfg_violation)
  );

  prediv_core #(.DIV_W(DIV_W)) core_i (
    .clk      (clk_src),
    .rst_n    (rst_int_n),
    .req_i    (req),
    .active_o (active),
    .phase_o  (phase)
  );

  prediv_settle #(.SETTLE_CYC(SETTLE_CYC)) settle_i (
    .clk      (clk_src),
    .rst_n    (rst_int_n),
    .active_i (active),
    .settle_o (settle_ok)
  );

  assign path    = active ? PATH_DIVIDED : PATH_BYPASS;
  assign clk_out = (path == PATH_DIVIDED) ? phase : clk_src;

  // R5
  enable_needs_block_chk: assert property (@(posedge clk_src) disable iff (!rst_int_n)
    $rose(active) |-> $past(src_is_osc && async_blocked));
  // R6
  viol_keeps_bypass_chk: assert property (@(posedge clk_src) disable iff (!rst_int_n)
    (cfg_violation && !active) |=> !active);
  // R8
  settle_low_active_chk: assert property (@(posedge clk_src) disable iff (!rst_int_n)
    active |-> !settle_ok);
endmodule

// File: tb/mclk_prediv_tb_top.sv
module mclk_prediv_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] div_sel = '0;
  logic       src_is_osc = 1'b0;
  logic       async_blocked = 1'b0;
  logic       clk_out, settle_ok, cfg_violation;
  int         n_tests = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  mclk_prediv dut_i (
    .clk_src       (clk),
    .rst_n         (rst_n),
    .div_sel       (div_sel),
    .src_is_osc    (src_is_osc),
    .async_blocked (async_blocked),
    .clk_out       (clk_out),
    .settle_ok     (settle_ok),
    .cfg_violation (cfg_violation)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(100000 * 4);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    int hi;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();
    // R9 reset state
    check("R9 clk_out", int'(clk_out), 1);
    check("R9 settle_ok", int'(settle_ok), 1);
    check("R9 cfg_violation", int'(cfg_violation), 0);
    // R1 bypass follows source low phase
    @(negedge clk); #1;
    check("R1 clk_out low", int'(clk_out), 0);
    step();

    // R5 enable before qualification is ignored
    src_is_osc = 1'b1; async_blocked = 1'b1;
    repeat (5) step();
    div_sel = 4'd3;
    step();
    check("R5 violation early", int'(cfg_violation), 1);
    for (int i = 0; i < 12; i++) begin
      step();
      check("R6 stays bypass", int'(clk_out), 1);
    end
    check("R6 flag sticky", int'(cfg_violation), 1);
    div_sel = 4'd0;
    step();
    check("R6 flag cleared", int'(cfg_violation), 0);

    // R5 async requests not blocked
    async_blocked = 1'b0;
    div_sel = 4'd5;
    step();
    check("R5 violation unblocked", int'(cfg_violation), 1);
    repeat (4) begin
      step();
      check("R5 unblocked bypass", int'(clk_out), 1);
    end
    div_sel = 4'd0; async_blocked = 1'b1;
    repeat (12) step();
    check("R5 no flag after clear", int'(cfg_violation), 0);

    // R2 R3 sweep every ratio, R8 settle timing
    for (int n = 1; n <= 15; n++) begin
      hi = (n + 2) / 2;
      div_sel = 4'(n);
      for (int i = 0; i < 3 * (n + 1); i++) begin
        step();
        check($sformatf("R2 R3 n=%0d i=%0d", n, i), int'(clk_out),
              ((i % (n + 1)) < hi) ? 1 : 0);
        check("R8 low while active", int'(settle_ok), 0);
      end
      div_sel = 4'd0;
      for (int j = 1; j <= 20; j++) begin
        step();
        if (j == 16) check($sformatf("R8 not yet n=%0d", n), int'(settle_ok), 0);
        if (j == 17) check($sformatf("R8 settled n=%0d", n), int'(settle_ok), 1);
      end
    end

    // R4 change mid-period: 3 -> 1
    div_sel = 4'd3;
    step();
    check("R4 k0", int'(clk_out), 1);
    step();
    check("R4 k1", int'(clk_out), 1);
    div_sel = 4'd1;
    step(); check("R4 k2 old", int'(clk_out), 0);
    step(); check("R4 k3 old", int'(clk_out), 0);
    step(); check("R4 k4 new", int'(clk_out), 1);
    step(); check("R4 k5 new", int'(clk_out), 0);
    step(); check("R4 k6 new", int'(clk_out), 1);
    step(); check("R4 k7 new", int'(clk_out), 0);
    div_sel = 4'd0;
    repeat (20) step();

    // R7 source leaves the oscillator while active
    div_sel = 4'd3;
    step();
    src_is_osc = 1'b0;
    step(); check("R7 flag", int'(cfg_violation), 1);
    step(); check("R7 k2 old", int'(clk_out), 0);
    step(); check("R7 k3 old", int'(clk_out), 0);
    step(); check("R7 k4", int'(clk_out), 1);
    step(); check("R7 k5 bypass", int'(clk_out), 1);
    step(); check("R7 k6 bypass", int'(clk_out), 1);
    src_is_osc = 1'b1; div_sel = 4'd0;
    repeat (14) step();

    // R8 disable from the start of a period
    div_sel = 4'd3;
    step();
    check("R8 active low", int'(settle_ok), 0);
    div_sel = 4'd0;
    for (int k = 1; k <= 20; k++) begin
      step();
      if (k == 19) check("R8 k19", int'(settle_ok), 0);
      if (k == 20) check("R8 k20", int'(settle_ok), 1);
    end
    @(negedge clk); #1;
    check("R1 bypass low again", int'(clk_out), 0);
    step();
    check("R1 bypass high again", int'(clk_out), 1);

    finish_run();
  end
endmodule